// File: doc/BRIEF.md
# Aging Command Queue

This block holds a small set of pending memory commands, eight by default, that several masters have issued. Each held command carries a master identifier, an address, a direction (read or write) and a priority. Every cycle the queue offers one candidate to a downstream scheduler, which takes it by pulsing an accept strobe. Storage is kept in arrival order. Slot 0 always holds the oldest command. When a command leaves, the younger ones move down one slot.

A command may only be offered when no older command from the same master forbids it. Two commands of the same direction from one master always leave in arrival order. A read also may not overtake an older write from its own master to the same 2048-byte region. Among the commands allowed to leave, the queue offers the one with the highest priority. When priorities are equal, the oldest wins.

To stop a stream of urgent commands from holding back a low-priority one forever, a counter tracks completed transfers. Once this counter reaches a programmable limit, the oldest command is offered whatever its priority. The boost ends as soon as that command is accepted.

Top module: `cmd_age_queue`

## Requirements
- R1: `enq_ready` is low exactly when all DEPTH slots are occupied, and an enqueue attempted while it is low stores nothing.
- R2: `deq_valid` is high whenever at least one command is held. The `deq_*` outputs show the offered command, and an accepted command is removed while the others keep their relative arrival order.
- R3: Without a boost, the offered command is the allowed command with the largest `deq_prio` value (3 is the most urgent for a 2-bit field). Ties go to the oldest command.
- R4: Two commands from the same master with the same direction (`wr`=1 write, `wr`=0 read) are offered in arrival order.
- R5: A read is not offered while an older write from the same master is held whose address bits [ADDR_W-1:11] match its own. A read to a different 2048-byte region may overtake that write.
- R6: The age counter counts `xfer_done` pulses and saturates at its all-ones value. It is cleared in the cycle after the command in slot 0 is accepted, and clearing wins over counting.
- R7: When `age_limit` is nonzero and the age counter is at least `age_limit`, the oldest held command is offered regardless of priority, until it is accepted.
- R8: When `age_limit` is zero the boost never applies, however many transfers have completed.
- R9: An enqueue and an accept in the same cycle both take effect. The new command becomes the youngest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | New command present |
| enq_ready | output | 1 | Queue can take a command |
| enq_id | input | ID_W | Master identifier of new command |
| enq_addr | input | ADDR_W | Byte address of new command |
| enq_wr | input | 1 | 1 = write, 0 = read |
| enq_prio | input | PRIO_W | Priority, larger is more urgent |
| deq_valid | output | 1 | A candidate is offered |
| deq_id | output | ID_W | Master identifier of candidate |
| deq_addr | output | ADDR_W | Address of candidate |
| deq_wr | output | 1 | Direction of candidate |
| deq_prio | output | PRIO_W | Stored priority of candidate |
| deq_accept | input | 1 | Scheduler takes the candidate this cycle |
| xfer_done | input | 1 | One-cycle pulse per completed transfer |
| age_limit | input | CNT_W | Transfer count that triggers the boost; 0 disables it |

## Verification
The assertions assume that the scheduler raises `deq_accept` only when it intends to take the offered command, and that `enq_valid` held while `enq_ready` is low has no lasting meaning. The ordering checks also assume that `age_limit` only changes while no transfer is counted against it. The stimulus raises `enq_valid` only below capacity, except in one deliberate full-queue attempt. It changes `age_limit` only between phases and drives `xfer_done` only as isolated single-cycle pulses, so each phase starts from a known counter value.

// File: rtl/cmd_age_queue.sv
module cmd_age_queue #(
  parameter int DEPTH     = 8,
  parameter int ID_W      = 3,
  parameter int ADDR_W    = 32,
  parameter int PRIO_W    = 2,
  parameter int CNT_W     = 8,
  parameter int RGN_BITS  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [ID_W-1:0]   enq_id,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic              enq_wr,
  input  logic [PRIO_W-1:0] enq_prio,
  output logic              deq_valid,
  output logic [ID_W-1:0]   deq_id,
  output logic [ADDR_W-1:0] deq_addr,
  output logic              deq_wr,
  output logic [PRIO_W-1:0] deq_prio,
  input  logic              deq_accept,
  input  logic              xfer_done,
  input  logic [CNT_W-1:0]  age_limit
);
  localparam int IW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [ID_W-1:0]   q_id   [DEPTH];
  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic              q_wr   [DEPTH];
  logic [PRIO_W-1:0] q_prio [DEPTH];
  logic [NW-1:0]     used;
  logic [CNT_W-1:0]  age_cnt;
  logic [DEPTH-1:0]  elig;
  logic [IW-1:0]     sel;
  logic [IW-1:0]     wp;
  logic [PRIO_W-1:0] best;
  logic              aged;
  logic              enq_fire;
  logic              deq_fire;

  assign enq_ready = (used != NW'(DEPTH));
  assign deq_valid = (used != '0);
  assign enq_fire  = enq_valid && enq_ready;
  assign deq_fire  = deq_valid && deq_accept;
  assign aged      = (age_limit != '0) && (age_cnt >= age_limit) && deq_valid;
  assign wp        = IW'(used - NW'(deq_fire));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = (NW'(i) < used);
      for (int j = 0; j < i; j++)
        if (q_id[j] == q_id[i] &&
            (q_wr[j] == q_wr[i] ||
             (q_wr[j] && !q_wr[i] &&
              q_addr[j][ADDR_W-1:RGN_BITS] == q_addr[i][ADDR_W-1:RGN_BITS])))
          elig[i] = 1'b0;
    end
  end

  always_comb begin
    sel  = '0;
    best = q_prio[0];
    if (!aged)
      for (int i = 1; i < DEPTH; i++)
        if (elig[i] && q_prio[i] > best) begin
          sel  = IW'(i);
          best = q_prio[i];
        end
  end

  assign deq_id   = q_id[sel];
  assign deq_addr = q_addr[sel];
  assign deq_wr   = q_wr[sel];
  assign deq_prio = q_prio[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        q_id[k]   <= '0;
        q_addr[k] <= '0;
        q_wr[k]   <= 1'b0;
        q_prio[k] <= '0;
      end
    end else begin
      if (deq_fire)
        for (int k = 0; k < DEPTH - 1; k++)
          if (IW'(k) >= sel) begin
            q_id[k]   <= q_id[k+1];
            q_addr[k] <= q_addr[k+1];
            q_wr[k]   <= q_wr[k+1];
            q_prio[k] <= q_prio[k+1];
          end
      if (enq_fire) begin
        q_id[wp]   <= enq_id;
        q_addr[wp] <= enq_addr;
        q_wr[wp]   <= enq_wr;
        q_prio[wp] <= enq_prio;
      end
      used <= used + NW'(enq_fire) - NW'(deq_fire);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      age_cnt <= '0;
    else if (deq_fire && sel == '0)
      age_cnt <= '0;
    else if (xfer_done && age_cnt != '1)
      age_cnt <= age_cnt + 1'b1;
  end
endmodule

// File: rtl/cmd_age_queue_chk.sv
module cmd_age_queue_chk #(
  parameter int DEPTH    = 8,
  parameter int ID_W     = 3,
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 8,
  parameter int RGN_BITS = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_valid,
  input logic              enq_ready,
  input logic              deq_valid,
  input logic              deq_accept,
  input logic [ID_W-1:0]   deq_id,
  input logic [ADDR_W-1:0] deq_addr,
  input logic              deq_wr,
  input logic [CNT_W-1:0]  age_limit,
  input logic [$clog2(DEPTH+1)-1:0] used,
  input logic [$clog2(DEPTH)-1:0]   sel,
  input logic [CNT_W-1:0]  age_cnt,
  input logic [ID_W-1:0]   q_id   [DEPTH],
  input logic [ADDR_W-1:0] q_addr [DEPTH],
  input logic              q_wr   [DEPTH]
);
  localparam int IW = $clog2(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= ($clog2(DEPTH+1))'(DEPTH)); // R1
  AST_FULL_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_ready |-> deq_valid); // R1
  AST_ENQ_MAKES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready && !(deq_valid && deq_accept)) |=> deq_valid); // R2
  AST_AGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && deq_accept && sel == '0) |=> age_cnt == '0); // R6
  AST_BOOST_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (age_limit != '0 && age_cnt >= age_limit && deq_valid) |-> sel == '0); // R7

  for (genvar j = 0; j < DEPTH - 1; j++) begin : g_older
    AST_SAME_DIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_valid && deq_accept && sel > IW'(j))
        |-> !(q_id[j] == deq_id && q_wr[j] == deq_wr)); // R4
    AST_RAW_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_valid && deq_accept && sel > IW'(j) && !deq_wr)
        |-> !(q_id[j] == deq_id && q_wr[j] &&
              q_addr[j][ADDR_W-1:RGN_BITS] == deq_addr[ADDR_W-1:RGN_BITS])); // R5
  end
endmodule

bind cmd_age_queue cmd_age_queue_chk #(
  .DEPTH(DEPTH), .ID_W(ID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RGN_BITS(RGN_BITS)
) u_chk (.*);

// File: tb/sim_cmd_age_queue.sv
module sim_cmd_age_queue;
  typedef struct packed {
    logic [2:0]  id;
    logic [31:0] a;
    logic        w;
    logic [1:0]  p;
  } item_t;

  logic        clk = 0, rst_n = 0;
  logic        enq_valid = 0, enq_wr = 0, deq_accept = 0, xfer_done = 0;
  logic [2:0]  enq_id = 0;
  logic [31:0] enq_addr = 0;
  logic [1:0]  enq_prio = 0;
  logic [7:0]  age_limit = 0;
  logic        enq_ready, deq_valid, deq_wr;
  logic [2:0]  deq_id;
  logic [31:0] deq_addr;
  logic [1:0]  deq_prio;

  int    checks = 0, fails = 0;
  bit    done = 0;
  item_t exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cmd_age_queue u0 (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_out(input logic [2:0] id, input logic [31:0] a,
                            input logic w, input logic [1:0] p, input string tag);
    exp_q.push_back('{id, a, w, p});
    tag_q.push_back(tag);
  endtask

  task automatic enq(input logic [2:0] id, input logic [31:0] a,
                     input logic w, input logic [1:0] p);
    @(negedge clk);
    enq_valid = 1; enq_id = id; enq_addr = a; enq_wr = w; enq_prio = p;
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic drain(input int n);
    repeat (n) begin
      @(negedge clk);
      deq_accept = 1;
    end
    @(negedge clk);
    deq_accept = 0;
  endtask

  task automatic pulse(input int n);
    repeat (n) begin
      @(negedge clk);
      xfer_done = 1;
      @(negedge clk);
      xfer_done = 0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && deq_valid && deq_accept) begin
      if (exp_q.size() == 0)
        chk(0, "R2", "unexpected dequeue id", 64'(deq_id), 64'hFF);
      else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({deq_id, deq_addr, deq_wr, deq_prio} == e, t, "dequeued item",
            64'({deq_id, deq_addr, deq_wr, deq_prio}), 64'(e));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk(enq_ready == 1, "R1", "ready after reset", 64'(enq_ready), 1);
    chk(deq_valid == 0, "R2", "valid after reset", 64'(deq_valid), 0);

    // R3: priority selection, oldest wins ties
    enq(0, 32'h0000, 1, 0);
    enq(1, 32'h2000, 0, 3);
    enq(2, 32'h4000, 1, 1);
    enq(3, 32'h6000, 0, 3);
    expect_out(1, 32'h2000, 0, 3, "R3");
    expect_out(3, 32'h6000, 0, 3, "R3");
    expect_out(2, 32'h4000, 1, 1, "R3");
    expect_out(0, 32'h0000, 1, 0, "R3");
    drain(4);

    // R4: same-master same-direction order
    enq(0, 32'h0100, 1, 0);
    enq(0, 32'h5000, 1, 3);
    enq(1, 32'h0200, 0, 0);
    enq(1, 32'h9000, 0, 3);
    expect_out(0, 32'h0100, 1, 0, "R4");
    expect_out(0, 32'h5000, 1, 3, "R4");
    expect_out(1, 32'h0200, 0, 0, "R4");
    expect_out(1, 32'h9000, 0, 3, "R4");
    drain(4);

    // R5: read after write, same region blocked
    enq(4, 32'h1000, 1, 0);
    enq(4, 32'h17FC, 0, 3);
    expect_out(4, 32'h1000, 1, 0, "R5");
    expect_out(4, 32'h17FC, 0, 3, "R5");
    drain(2);
    // R5: different region may pass
    enq(5, 32'h1000, 1, 0);
    enq(5, 32'h1800, 0, 3);
    expect_out(5, 32'h1800, 0, 3, "R5");
    expect_out(5, 32'h1000, 1, 0, "R5");
    drain(2);

    // R6/R7: aging boost
    age_limit = 3;
    enq(0, 32'h0040, 1, 0);
    for (int i = 1; i <= 4; i++) enq(3'(i), 32'h8000 * i, 0, 3);
    enq(5, 32'h0080, 1, 0);
    pulse(2);
    #2;
    chk(deq_id == 1, "R7", "no boost below limit", 64'(deq_id), 1);
    expect_out(1, 32'h8000, 0, 3, "R3");
    drain(1);
    pulse(1);
    #2;
    chk(deq_id == 0, "R7", "boosted oldest offered", 64'(deq_id), 0);
    expect_out(0, 32'h0040, 1, 0, "R7");
    drain(1);
    #2;
    chk(deq_id == 2, "R6", "boost ends after oldest leaves", 64'(deq_id), 2);
    expect_out(2, 32'h10000, 0, 3, "R6");
    expect_out(3, 32'h18000, 0, 3, "R6");
    expect_out(4, 32'h20000, 0, 3, "R6");
    expect_out(5, 32'h0080, 1, 0, "R6");
    drain(4);

    // R8: limit zero disables; R6 saturation
    age_limit = 0;
    enq(0, 32'h0300, 1, 0);
    enq(6, 32'h0400, 0, 3);
    pulse(300);
    #2;
    chk(deq_id == 6, "R8", "limit zero never boosts", 64'(deq_id), 6);
    @(negedge clk);
    age_limit = 8'hFF;
    #2;
    chk(deq_id == 0, "R6", "counter saturated at all ones", 64'(deq_id), 0);
    expect_out(0, 32'h0300, 1, 0, "R6");
    expect_out(6, 32'h0400, 0, 3, "R8");
    drain(2);
    age_limit = 0;

    // R1: full queue, extra enqueue ignored
    for (int i = 0; i < 8; i++) enq(3'(i), 32'h100 * i, 0, 0);
    #2;
    chk(enq_ready == 0, "R1", "ready low when full", 64'(enq_ready), 0);
    enq(7, 32'hDEAD000, 1, 3);
    for (int i = 0; i < 8; i++) expect_out(3'(i), 32'h100 * i, 0, 0, "R1");
    drain(8);
    #2;
    chk(deq_valid == 0, "R1", "extra enqueue was not stored", 64'(deq_valid), 0);

    // R9: simultaneous enqueue and accept
    enq(1, 32'hA000, 0, 1);
    expect_out(1, 32'hA000, 0, 1, "R9");
    @(negedge clk);
    enq_valid = 1; enq_id = 2; enq_addr = 32'hB000; enq_wr = 0; enq_prio = 2;
    deq_accept = 1;
    @(negedge clk);
    enq_valid = 0; deq_accept = 0;
    #2;
    chk(deq_valid == 1 && deq_id == 2, "R9", "new entry held after swap",
        64'({deq_valid, deq_id}), 64'({1'b1, 3'd2}));
    expect_out(2, 32'hB000, 0, 2, "R9");
    drain(1);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "scoreboard empty", 64'(exp_q.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule